// File: doc/BRIEF.md
# Memory-Mapped Pin Port with Atomic Set/Clear/Toggle Aliases

This block is a general-purpose pin port of up to 32 pins, reached through a small single-cycle register bus. Each cycle the bus presents a word address, a write enable and a write word. Read data is registered and appears one cycle after the address. The block holds an output-value register and a pin-direction register. Both are driven straight to the pads as the output value vector and the output-enable vector. It also returns the pad levels after they pass through a synchronizer.

Each of the two registers can be written as a whole word. It can also be written through three alias addresses that combine the written word with the current contents by OR, AND or XOR. Software can therefore set, clear or toggle any group of pins in one bus write, with no read-modify-write sequence that another agent could interleave with. A read-only capability word reports the number of implemented pins and a code that says how pin interrupts are routed to interrupt lines.

Top module: `gpio_alias_port`

## Requirements
- R1: While `rst` is high at a rising edge, `pad_out`, `pad_oe` and `bus_rdata` become zero, so every pin is an input after reset.
- R2: A write to address 1 replaces the output-value register with the written word at the rising edge where `bus_we` is high. The new value is on `pad_out` after that edge.
- R3: A write to address 4 ORs the written word into the output-value register, setting each bit where the word has a one.
- R4: A write to address 5 ANDs the written word into the output-value register, keeping only the bits where the word has a one.
- R5: A write to address 6 XORs the written word into the output-value register, inverting each bit where the word has a one.
- R6: The direction register drives `pad_oe`, with 1 meaning output and 0 meaning input. Address 2 replaces it. Addresses 7, 8 and 9 apply OR, AND and XOR respectively.
- R7: Without a write, `pad_out` and `pad_oe` hold their values.
- R8: Reading address 0 returns the pad levels through a two-stage synchronizer. A change of `pad_in` sampled at one rising edge shows in `bus_rdata` after the third rising edge with address 0 held, and not after the second.
- R9: Writes to address 0 (pin levels) and address 3 (capability) change neither register.
- R10: Reading address 3 returns the pin count in bits 5:0 and the interrupt routing code `IRQ_ROUTE` in bits 12:8, with all other bits zero.
- R11: Bits at and above `NPINS` are not stored, are not driven, and read as zero.
- R12: `bus_rdata` after a rising edge shows the value the addressed register held before that edge, even when the same edge writes it. Addresses 1, 4, 5 and 6 read the output-value register. Addresses 2, 7, 8 and 9 read the direction register. Addresses 10 to 15 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Registered read word |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Output value to pads |
| pad_oe | output | NPINS | Output enable to pads, 1 = drive |

## Verification
The bench builds the port with `NPINS` = 12 and `IRQ_ROUTE` = 3. With these values, write words that carry ones in bits 31:12 show whether the unimplemented bits are really dropped on every alias, and the capability word has both of its fields non-zero. A behavioural model follows every alias, the synchronizer delay and the read-before-write ordering each cycle, through directed sequences and a long run of random bus traffic and pad changes.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_PIN     = 4'd0,
    A_OUT     = 4'd1,
    A_DIR     = 4'd2,
    A_CAP     = 4'd3,
    A_OUT_OR  = 4'd4,
    A_OUT_AND = 4'd5,
    A_OUT_XOR = 4'd6,
    A_DIR_OR  = 4'd7,
    A_DIR_AND = 4'd8,
    A_DIR_XOR = 4'd9
  } reg_addr_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_OR   = 2'd1,
    OP_AND  = 2'd2,
    OP_XOR  = 2'd3
  } alias_op_e;

  typedef struct packed {
    logic      hit;
    alias_op_e op;
  } wr_cmd_t;
endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
  import gpio_alias_pkg::*;
(
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output wr_cmd_t           out_cmd,
  output wr_cmd_t           dir_cmd
);
  always_comb begin
    out_cmd = '{hit: 1'b0, op: OP_LOAD};
    dir_cmd = '{hit: 1'b0, op: OP_LOAD};
    if (we) begin
      unique case (addr)
        A_OUT:     out_cmd = '{hit: 1'b1, op: OP_LOAD};
        A_OUT_OR:  out_cmd = '{hit: 1'b1, op: OP_OR};
        A_OUT_AND: out_cmd = '{hit: 1'b1, op: OP_AND};
        A_OUT_XOR: out_cmd = '{hit: 1'b1, op: OP_XOR};
        A_DIR:     dir_cmd = '{hit: 1'b1, op: OP_LOAD};
        A_DIR_OR:  dir_cmd = '{hit: 1'b1, op: OP_OR};
        A_DIR_AND: dir_cmd = '{hit: 1'b1, op: OP_AND};
        A_DIR_XOR: dir_cmd = '{hit: 1'b1, op: OP_XOR};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_alias_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  wr_cmd_t      cmd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    unique case (cmd.op)
      OP_OR:   nxt = q | wdata;
      OP_AND:  nxt = q & wdata;
      OP_XOR:  nxt = q ^ wdata;
      default: nxt = wdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (cmd.hit) q <= nxt;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_alias_pkg::*;
#(
  parameter int W         = 32,
  parameter int IRQ_ROUTE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      pin_lvl,
  input  logic [W-1:0]      out_q,
  input  logic [W-1:0]      dir_q,
  output logic [BUS_W-1:0]  rdata
);
  logic [BUS_W-1:0] pin_x, out_x, dir_x, cap_w, sel;

  always_comb begin
    pin_x = '0;
    out_x = '0;
    dir_x = '0;
    pin_x[W-1:0] = pin_lvl;
    out_x[W-1:0] = out_q;
    dir_x[W-1:0] = dir_q;
    cap_w        = '0;
    cap_w[5:0]   = 6'(W);
    cap_w[12:8]  = 5'(IRQ_ROUTE);
  end

  always_comb begin
    unique case (addr)
      A_PIN:                              sel = pin_x;
      A_OUT, A_OUT_OR, A_OUT_AND, A_OUT_XOR: sel = out_x;
      A_DIR, A_DIR_OR, A_DIR_AND, A_DIR_XOR: sel = dir_x;
      A_CAP:                              sel = cap_w;
      default:                            sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port #(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_ROUTE   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  import gpio_alias_pkg::*;

  wr_cmd_t          out_cmd, dir_cmd;
  logic [NPINS-1:0] pin_lvl;
  logic [NPINS-1:0] wd;

  assign wd = bus_wdata[NPINS-1:0];

  gpio_wr_decode u_dec (
    .we      (bus_we),
    .addr    (bus_addr),
    .out_cmd (out_cmd),
    .dir_cmd (dir_cmd)
  );

  gpio_alias_reg #(.W(NPINS)) u_out (
    .clk (clk), .rst (rst), .cmd (out_cmd), .wdata (wd), .q (pad_out)
  );

  gpio_alias_reg #(.W(NPINS)) u_dir (
    .clk (clk), .rst (rst), .cmd (dir_cmd), .wdata (wd), .q (pad_oe)
  );

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (pad_in), .q (pin_lvl)
  );

  gpio_rd_mux #(.W(NPINS), .IRQ_ROUTE(IRQ_ROUTE)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .pin_lvl (pin_lvl),
    .out_q   (pad_out),
    .dir_q   (pad_oe),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/gpio_alias_port_chk.sv
module gpio_alias_port_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       bus_addr,
  input logic             bus_we,
  input logic [31:0]      bus_wdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe
);
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_out == '0 && pad_oe == '0));

  a_r3_or_sets: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 4'd4) |=>
      pad_out == ($past(pad_out) | $past(bus_wdata[NPINS-1:0])));

  a_r4_and_keeps: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 4'd5) |=>
      pad_out == ($past(pad_out) & $past(bus_wdata[NPINS-1:0])));

  a_r5_xor_flips: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 4'd6) |=>
      pad_out == ($past(pad_out) ^ $past(bus_wdata[NPINS-1:0])));

  a_r6_dir_or_sets: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 4'd7) |=>
      pad_oe == ($past(pad_oe) | $past(bus_wdata[NPINS-1:0])));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> ($stable(pad_out) && $stable(pad_oe)));

  a_r9_ro_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == 4'd0 || bus_addr == 4'd3)) |=>
      ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_alias_port gpio_alias_port_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/gpio_alias_port_tb.sv
`timescale 1ns/1ps
module gpio_alias_port_tb;
  localparam int NP = 12;
  localparam int IRQR = 3;
  localparam logic [31:0] M = (32'd1 << NP) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  always #2.5 clk = ~clk;

  gpio_alias_port #(.NPINS(NP), .SYNC_STAGES(2), .IRQ_ROUTE(IRQR)) u_dut (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_we (bus_we),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe)
  );

  // behavioural reference
  logic [31:0] out_m, dir_m, rd_m, s1, s2;
  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      out_m = 0; dir_m = 0; rd_m = 0; s1 = 0; s2 = 0;
    end else begin
      case (bus_addr)
        4'd0: rd_m = s2;
        4'd1, 4'd4, 4'd5, 4'd6: rd_m = out_m;
        4'd2, 4'd7, 4'd8, 4'd9: rd_m = dir_m;
        4'd3: rd_m = (32'(IRQR) << 8) | 32'(NP);
        default: rd_m = 0;
      endcase
      s2 = s1;
      s1 = 32'(pad_in);
      if (bus_we) begin
        case (bus_addr)
          4'd1: out_m = bus_wdata & M;
          4'd4: out_m = (out_m | bus_wdata) & M;
          4'd5: out_m = out_m & bus_wdata;
          4'd6: out_m = (out_m ^ bus_wdata) & M;
          4'd2: dir_m = bus_wdata & M;
          4'd7: dir_m = (dir_m | bus_wdata) & M;
          4'd8: dir_m = dir_m & bus_wdata;
          4'd9: dir_m = (dir_m ^ bus_wdata) & M;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2-R5 pad_out vs model", 32'(pad_out), out_m);
      chk("R6 pad_oe vs model", 32'(pad_oe), dir_m);
      chk("R12 bus_rdata vs model", bus_rdata, rd_m);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [NP-1:0] hold_out;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 pad_out after reset", 32'(pad_out), 0);
    chk("R1 pad_oe after reset", 32'(pad_oe), 0);
    chk("R1 bus_rdata after reset", bus_rdata, 0);

    wr(4'd1, 32'hA5A5_A5A5);
    chk("R2 plain write", 32'(pad_out), 32'h5A5);
    rd(4'd1, v);
    chk("R11 upper bits read zero", v, 32'h5A5);
    wr(4'd4, 32'hFFFF_000F);
    chk("R3 OR alias / R7 same edge", 32'(pad_out), 32'h5AF);
    wr(4'd5, 32'h0000_0FF0);
    chk("R4 AND alias", 32'(pad_out), 32'h5A0);
    wr(4'd6, 32'hF000_00FF);
    chk("R5 XOR alias", 32'(pad_out), 32'h55F);

    wr(4'd7, 32'h0F0);
    chk("R6 dir OR", 32'(pad_oe), 32'h0F0);
    wr(4'd8, 32'h030);
    chk("R6 dir AND", 32'(pad_oe), 32'h030);
    wr(4'd9, 32'h003);
    chk("R6 dir XOR", 32'(pad_oe), 32'h033);
    wr(4'd2, 32'hFFFF_F800);
    chk("R6 dir plain / R11 masked", 32'(pad_oe), 32'h800);

    hold_out = pad_out;
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd3, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R9 RO writes keep pad_out", 32'(pad_out), 32'(hold_out));
    chk("R9 RO writes keep pad_oe", 32'(pad_oe), 32'h800);
    chk("R7 idle holds pad_out", 32'(pad_out), 32'h55F);

    rd(4'd3, v);
    chk("R10 capability word", v, 32'h0000_030C);

    rd(4'd0, v);
    pad_in = 12'h9C3;
    @(negedge clk);
    @(negedge clk);
    chk("R8 not yet after second edge", bus_rdata, 0);
    @(negedge clk);
    chk("R8 visible after third edge", bus_rdata, 32'h9C3);

    bus_addr = 4'd1; bus_we = 1'b1; bus_wdata = 32'h123;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R12 read shows pre-write value", bus_rdata, 32'h55F);
    chk("R2 same-edge write landed", 32'(pad_out), 32'h123);
    rd(4'd15, v);
    chk("R12 unmapped reads zero", v, 0);

    for (int i = 0; i < 3000; i++) begin
      bus_addr  = 4'($urandom_range(0, 15));
      bus_we    = ($urandom_range(0, 2) != 0);
      bus_wdata = $urandom;
      if ($urandom_range(0, 3) == 0) pad_in = NP'($urandom);
      if (i == 1500) rst = 1'b1;
      if (i == 1503) rst = 1'b0;
      @(negedge clk);
    end
    bus_we = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule